// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds one atomic reservation for a processor core and decides the outcome of a store-conditional. A load-linked event records the word address it read and marks the reservation live. Any write by another master to that same word clears it, as does any return-from-exception. When a store-conditional arrives, the block checks that the address is word aligned, waits for older shared-memory traffic to drain, then either writes the data to memory and returns 1, or writes nothing and returns 0. The returned value goes back into the instruction's source register.

The store-conditional works as an ordering point. While it waits for the drain, the monitor holds a drain request high. It performs the write only once the core's count of pending memory operations reads zero. A second store-conditional that arrives during this wait is dropped. A misaligned store-conditional never enters the drain. It raises an address exception on the next cycle and kills the reservation.

Top module: `llsc_resv_monitor`

## Requirements
- R1: While reset is held, and on the first cycle after it, drain_req, mem_we, rslt_valid and addr_exc are all 0, and no reservation is live.
- R2: A load-linked pulse (ll_valid) makes the reservation live for word ll_waddr. A later load-linked replaces both the word and the live state, so an SC to the earlier word fails.
- R3: A snoop write (snoop_valid) whose word address equals the reserved word clears the reservation. A snoop to any other word has no effect on it.
- R4: An exception-return pulse (eret_valid) clears the reservation.
- R5: An accepted aligned SC with a live reservation on the same word (sc_addr[AW-1:2]) produces, in the cycle after the drain completes, mem_we=1 with mem_addr=sc_addr and mem_wdata=sc_data, plus rslt_valid=1 and rslt_value=1.
- R6: Any other aligned SC produces rslt_valid=1 with rslt_value=0 in that same cycle and issues no memory write.
- R7: An SC with sc_addr[1:0] not equal to 0 raises addr_exc for one cycle, on the cycle after sc_valid. It produces no drain request, no memory write and no result, and it clears the reservation.
- R8: From the cycle after an aligned SC is accepted, drain_req stays 1 until a cycle in which pend_count is 0. The result appears on the next cycle and drain_req falls at that point.
- R9: Every SC outcome (success, failure or address exception) clears the reservation, so a repeated SC without a new load-linked fails.
- R10: An sc_valid pulse that arrives while drain_req is 1 is ignored and produces no result of its own.
- R11: When a load-linked occurs in the same cycle as a snoop hit, an exception return or an SC outcome, the new reservation is live afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ll_valid | input | 1 | Load-linked event |
| ll_waddr | input | AW-2 | Word address read by the load-linked |
| sc_valid | input | 1 | Store-conditional request |
| sc_addr | input | AW | Byte address of the store-conditional |
| sc_data | input | DW | Data to store |
| snoop_valid | input | 1 | Write by another master observed |
| snoop_waddr | input | AW-2 | Word address of that write |
| eret_valid | input | 1 | Exception-return executed |
| pend_count | input | CW | Outstanding older shared-memory operations |
| drain_req | output | 1 | Request to drain older memory operations |
| mem_we | output | 1 | Memory write strobe for a successful SC |
| mem_addr | output | AW | Write address |
| mem_wdata | output | DW | Write data |
| rslt_valid | output | 1 | SC result is valid |
| rslt_value | output | DW | SC result for the source register: 1 or 0 |
| addr_exc | output | 1 | Address exception for a misaligned SC |

## Verification
The bench aims at the ordering cases at the reservation's edges. These are a snoop that hits the reserved word while the SC is still draining, a snoop to the neighbouring word, and a load-linked that lands in the same cycle as a kill. A design that checked the snoop against the full byte address would let a write to another byte of the same word slip through. A design that gave the kill priority over the new load-linked would fail an SC that should pass. The bench also holds pend_count above zero for several cycles and sends a second SC during that wait. A design that wrote before the drain finished, or that took the second request, would show an early mem_we or an extra result. It also repeats an SC without a new load-linked and sends a misaligned SC, which catch a design that leaves the reservation live after an outcome.

// File: rtl/llsc_pkg.sv
package llsc_pkg;

  typedef enum logic [0:0] {
    SC_IDLE  = 1'b0,
    SC_DRAIN = 1'b1
  } sc_state_e;

  // Byte offset within a word must be zero for a conditional store.
  function automatic logic word_aligned(input logic [1:0] byte_off);
    return byte_off == 2'b00;
  endfunction

endpackage

// File: rtl/resv_tracker.sv
module resv_tracker #(
  parameter int WAW = 30
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ll_set,
  input  logic [WAW-1:0] ll_word,
  input  logic           snoop_valid,
  input  logic [WAW-1:0] snoop_word,
  input  logic           eret,
  input  logic           sc_clear,
  output logic           resv_valid,
  output logic [WAW-1:0] resv_word
);

  logic           valid_q, valid_d;
  logic [WAW-1:0] word_q, word_d;
  logic           word_en;
  logic           snoop_hit;
  logic           kill;

  always_comb begin
    snoop_hit = snoop_valid && valid_q && (snoop_word == word_q);
    kill      = eret || snoop_hit || sc_clear;
    word_en   = ll_set;
    word_d    = ll_word;
    if (ll_set) begin
      valid_d = 1'b1;
    end else if (kill) begin
      valid_d = 1'b0;
    end else begin
      valid_d = valid_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (word_en) begin
      word_q <= word_d;
    end
  end

  assign resv_valid = valid_q;
  assign resv_word  = word_q;

endmodule

// File: rtl/sc_sequencer.sv
module sc_sequencer
  import llsc_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sc_valid,
  input  logic [AW-1:0] sc_addr,
  input  logic [DW-1:0] sc_data,
  input  logic [CW-1:0] pend_count,
  input  logic          resv_valid,
  input  logic [AW-3:0] resv_word,
  output logic          drain_req,
  output logic          sc_clear,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rslt_valid,
  output logic [DW-1:0] rslt_value,
  output logic          addr_exc
);

  localparam int WAW = AW - 2;

  sc_state_e     state_q, state_d;
  logic [AW-1:0] cap_addr_q;
  logic [DW-1:0] cap_data_q;
  logic          cap_en;
  logic          accept, misal, start, decide, pass;
  logic [WAW-1:0] cap_word;
  logic          we_q, rv_q, pass_q, exc_q;

  always_comb begin
    cap_word = cap_addr_q[AW-1:2];
    accept   = sc_valid && (state_q == SC_IDLE);
    misal    = accept && !word_aligned(sc_addr[1:0]);
    start    = accept && word_aligned(sc_addr[1:0]);
    decide   = (state_q == SC_DRAIN) && (pend_count == '0);
    pass     = decide && resv_valid && (resv_word == cap_word);
    cap_en   = start;
    sc_clear = misal || decide;
    state_d  = state_q;
    unique case (state_q)
      SC_IDLE:  if (start)  state_d = SC_DRAIN;
      SC_DRAIN: if (decide) state_d = SC_IDLE;
      default:  state_d = SC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SC_IDLE;
      we_q    <= 1'b0;
      rv_q    <= 1'b0;
      pass_q  <= 1'b0;
      exc_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      we_q    <= pass;
      rv_q    <= decide;
      pass_q  <= pass;
      exc_q   <= misal;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr_q <= '0;
      cap_data_q <= '0;
    end else if (cap_en) begin
      cap_addr_q <= sc_addr;
      cap_data_q <= sc_data;
    end
  end

  assign drain_req  = (state_q == SC_DRAIN);
  assign mem_we     = we_q;
  assign mem_addr   = cap_addr_q;
  assign mem_wdata  = cap_data_q;
  assign rslt_valid = rv_q;
  assign rslt_value = {{(DW-1){1'b0}}, pass_q};
  assign addr_exc   = exc_q;

endmodule

// File: rtl/llsc_resv_monitor.sv
module llsc_resv_monitor #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ll_valid,
  input  logic [AW-3:0] ll_waddr,
  input  logic          sc_valid,
  input  logic [AW-1:0] sc_addr,
  input  logic [DW-1:0] sc_data,
  input  logic          snoop_valid,
  input  logic [AW-3:0] snoop_waddr,
  input  logic          eret_valid,
  input  logic [CW-1:0] pend_count,
  output logic          drain_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          rslt_valid,
  output logic [DW-1:0] rslt_value,
  output logic          addr_exc
);

  localparam int WAW = AW - 2;

  logic           resv_valid;
  logic [WAW-1:0] resv_word;
  logic           sc_clear;

  resv_tracker #(.WAW(WAW)) u_resv (
    .clk         (clk),
    .rst_n       (rst_n),
    .ll_set      (ll_valid),
    .ll_word     (ll_waddr),
    .snoop_valid (snoop_valid),
    .snoop_word  (snoop_waddr),
    .eret        (eret_valid),
    .sc_clear    (sc_clear),
    .resv_valid  (resv_valid),
    .resv_word   (resv_word)
  );

  sc_sequencer #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_valid   (sc_valid),
    .sc_addr    (sc_addr),
    .sc_data    (sc_data),
    .pend_count (pend_count),
    .resv_valid (resv_valid),
    .resv_word  (resv_word),
    .drain_req  (drain_req),
    .sc_clear   (sc_clear),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .rslt_valid (rslt_valid),
    .rslt_value (rslt_value),
    .addr_exc   (addr_exc)
  );

endmodule

// File: rtl/llsc_resv_monitor_chk.sv
module llsc_resv_monitor_chk #(
  parameter int DW = 32,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          drain_req,
  input logic [CW-1:0] pend_count,
  input logic          mem_we,
  input logic          rslt_valid,
  input logic [DW-1:0] rslt_value,
  input logic          addr_exc
);

  p_we_succ_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (rslt_valid && rslt_value == DW'(1)));

  p_fail_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rslt_valid && rslt_value == '0) |-> !mem_we);

  p_result_bin_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rslt_valid |-> (rslt_value <= DW'(1)));

  p_exc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    addr_exc |-> (!mem_we && !rslt_valid && !drain_req));

  p_drain_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && pend_count != '0) |=> (drain_req && !rslt_valid));

  p_drain_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_req && pend_count == '0) |=> (rslt_valid && !drain_req));

endmodule

bind llsc_resv_monitor llsc_resv_monitor_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .drain_req  (drain_req),
  .pend_count (pend_count),
  .mem_we     (mem_we),
  .rslt_valid (rslt_valid),
  .rslt_value (rslt_value),
  .addr_exc   (addr_exc)
);

// File: tb/sim_llsc_resv_monitor.sv
module sim_llsc_resv_monitor;

  logic        clk;
  logic        rst_n;
  logic        ll_valid;
  logic [29:0] ll_waddr;
  logic        sc_valid;
  logic [31:0] sc_addr;
  logic [31:0] sc_data;
  logic        snoop_valid;
  logic [29:0] snoop_waddr;
  logic        eret_valid;
  logic [3:0]  pend_count;
  logic        drain_req, mem_we, rslt_valid, addr_exc;
  logic [31:0] mem_addr, mem_wdata, rslt_value;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string cur_req = "R1";

  llsc_resv_monitor u0 (
    .clk(clk), .rst_n(rst_n),
    .ll_valid(ll_valid), .ll_waddr(ll_waddr),
    .sc_valid(sc_valid), .sc_addr(sc_addr), .sc_data(sc_data),
    .snoop_valid(snoop_valid), .snoop_waddr(snoop_waddr),
    .eret_valid(eret_valid), .pend_count(pend_count),
    .drain_req(drain_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .rslt_valid(rslt_valid),
    .rslt_value(rslt_value), .addr_exc(addr_exc)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // Behavioural reference state.
  bit          m_live;
  logic [29:0] m_word;
  bit          m_wait;
  logic [31:0] m_a, m_d;
  bit          e_we, e_rv, e_val, e_exc;
  logic [31:0] e_ma, e_md;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (scenario %s) actual %0h expected %0h at cycle %0d",
               tag, cur_req, act, exp, cycles);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_live = 0; m_wait = 0; m_word = '0; m_a = '0; m_d = '0;
      e_we = 0; e_rv = 0; e_val = 0; e_exc = 0; e_ma = '0; e_md = '0;
    end else begin
      bit n_we, n_rv, n_val, n_exc, clr, hit;
      n_we = 0; n_rv = 0; n_val = 0; n_exc = 0; clr = 0;
      if (m_wait) begin
        if (pend_count == 0) begin
          n_rv  = 1;
          n_val = m_live && (m_word == m_a[31:2]);
          n_we  = n_val;
          clr   = 1;
          m_wait = 0;
        end
      end else if (sc_valid) begin
        if (sc_addr[1:0] != 2'b00) begin
          n_exc = 1;
          clr   = 1;
        end else begin
          m_wait = 1;
          m_a = sc_addr;
          m_d = sc_data;
        end
      end
      hit = snoop_valid && m_live && (snoop_waddr == m_word);
      if (ll_valid) begin
        m_live = 1;
        m_word = ll_waddr;
      end else if (eret_valid || hit || clr) begin
        m_live = 0;
      end
      e_we = n_we; e_rv = n_rv; e_val = n_val; e_exc = n_exc;
      if (n_we) begin
        e_ma = m_a;
        e_md = m_d;
      end
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst_n) begin
      check("R1 drain_req", {31'b0, drain_req}, 32'd0);
      check("R1 mem_we", {31'b0, mem_we}, 32'd0);
      check("R1 rslt_valid", {31'b0, rslt_valid}, 32'd0);
      check("R1 addr_exc", {31'b0, addr_exc}, 32'd0);
    end else begin
      check("R8 drain_req", {31'b0, drain_req}, {31'b0, m_wait});
      check(e_we ? "R5 mem_we" : "R6 mem_we", {31'b0, mem_we}, {31'b0, e_we});
      check("R9 rslt_valid", {31'b0, rslt_valid}, {31'b0, e_rv});
      check("R7 addr_exc", {31'b0, addr_exc}, {31'b0, e_exc});
      if (e_rv)
        check(e_val ? "R5 rslt_value" : "R6 rslt_value", rslt_value, {31'b0, e_val});
      if (e_we) begin
        check("R5 mem_addr", mem_addr, e_ma);
        check("R5 mem_wdata", mem_wdata, e_md);
      end
    end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
    ll_valid = 0; sc_valid = 0; snoop_valid = 0; eret_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic do_ll(input logic [31:0] a);
    ll_valid = 1; ll_waddr = a[31:2];
    step();
  endtask

  task automatic do_sc(input logic [31:0] a, input logic [31:0] d);
    sc_valid = 1; sc_addr = a; sc_data = d;
    step();
  endtask

  task automatic do_snoop(input logic [31:0] a);
    snoop_valid = 1; snoop_waddr = a[31:2];
    step();
  endtask

  task automatic do_eret();
    eret_valid = 1;
    step();
  endtask

  initial begin
    rst_n = 0;
    ll_valid = 0; ll_waddr = '0; sc_valid = 0; sc_addr = '0; sc_data = '0;
    snoop_valid = 0; snoop_waddr = '0; eret_valid = 0; pend_count = '0;
    idle(3);
    rst_n = 1;
    step();

    cur_req = "R1"; do_sc(32'h0000_0040, 32'h11); idle(3);        // no reservation after reset
    cur_req = "R5"; do_ll(32'h100); do_sc(32'h100, 32'hAA55_0001); idle(3);
    cur_req = "R9"; do_sc(32'h100, 32'h2); idle(3);                // repeat fails
    cur_req = "R3"; do_ll(32'h200); do_snoop(32'h204); do_sc(32'h200, 32'h3); idle(3);
    cur_req = "R3"; do_ll(32'h200); do_snoop(32'h202); do_sc(32'h200, 32'h4); idle(3);
    cur_req = "R4"; do_ll(32'h300); do_eret(); do_sc(32'h300, 32'h5); idle(3);
    cur_req = "R2"; do_ll(32'h400); do_ll(32'h500); do_sc(32'h400, 32'h6); idle(3);
    cur_req = "R2"; do_ll(32'h400); do_ll(32'h500); do_sc(32'h500, 32'h7); idle(3);
    cur_req = "R7"; do_ll(32'h600); do_sc(32'h602, 32'h8); do_sc(32'h601, 32'h8);
    do_sc(32'h600, 32'h9); idle(3);

    cur_req = "R8"; pend_count = 4'd3; do_ll(32'h700); do_sc(32'h700, 32'hCAFE);
    cur_req = "R10"; do_sc(32'h800, 32'hBAD);                      // ignored while draining
    pend_count = 4'd2; step(); pend_count = 4'd1; step(); step();
    pend_count = 4'd0; idle(3);

    cur_req = "R3"; pend_count = 4'd2; do_ll(32'h900); do_sc(32'h900, 32'hD);
    do_snoop(32'h900); pend_count = 4'd0; idle(3);

    cur_req = "R11"; do_ll(32'hA00); ll_valid = 1; ll_waddr = 30'h280;
    snoop_valid = 1; snoop_waddr = 30'h280; step(); do_sc(32'hA00, 32'hE); idle(3);
    cur_req = "R11"; ll_valid = 1; ll_waddr = 30'h2C0; eret_valid = 1; step();
    do_sc(32'hB00, 32'hF); idle(3);
    cur_req = "R11"; do_ll(32'hC00); do_sc(32'hC00, 32'h10);
    ll_valid = 1; ll_waddr = 30'h340; step();                      // LL with SC outcome
    do_sc(32'hD00, 32'h11); idle(3);
    cur_req = "R5"; do_ll(32'hFFFF_FFFC); do_sc(32'hFFFF_FFFC, 32'hFFFF_FFFF); idle(3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule